// File: doc/BRIEF.md
# Serial EEPROM Read Slave

This block is a slave-side model of a 256-byte serial EEPROM on a two-wire bus. It watches SCL and SDA levels, as a processor produces them by toggling general-purpose register bits, and it returns one output that says when the slave pulls SDA low. The slave never drives SDA high. When it releases the line, the line reads high.

A transfer begins with a start condition. The slave then takes in a control byte, acknowledges it, and takes in a word-address byte. A single bit counter runs across both bytes. When the address byte is complete, the slave loads the data register from the addressed byte of the image and acknowledges the address byte. In read mode, the data register is shifted out MSB-first during the address-byte clocks of the next transfer. Writes to the array, page writes and device-address matching are not part of this block.

The memory contents come from a computed image that is set by two parameters. A 128-byte variant is obtained by setting `DEPTH` to 128.

Top module: `serial_rom_slave`

## Requirements
- R1: After reset the slave releases SDA (`sda_low`=0) and waits for a start condition.
- R2: SDA falling while SCL stays high is a start condition. It always begins a new control byte, including in the middle of a byte, so the acknowledge comes only after eight further accepted bits.
- R3: SDA rising while SCL stays high is a stop condition. It releases SDA and returns the slave to waiting, so later SCL clocks produce no acknowledge and no drive.
- R4: While waiting (no transfer in progress and no acknowledge armed), all SCL and SDA activity is ignored. The output stays released and the data register is not shifted, so the next read still presents the previously loaded byte.
- R5: A bit is accepted only on an SCL rising edge at which SDA did not also change. An SDA change that coincides with the SCL rise is neither sampled nor counted.
- R6: After the eighth accepted control bit, an acknowledge is armed. On the next SCL rising edge the slave pulls SDA low (`sda_low`=1) and holds it low until the next accepted SCL rise.
- R7: The LSB of the control byte selects the mode: 1 = read, 0 = write. In write mode the slave keeps SDA released during the eight address-byte clocks.
- R8: In read mode, at each address-byte SCL rise the slave presents the data register MSB-first: `sda_low` = NOT of the current bit. The level holds until the next accepted rise.
- R9: On the eighth address bit, the data register loads image byte `(A*IMG_MUL + IMG_ADD) mod 256` (defaults 29 and 90), where A is the received address modulo `DEPTH`. An acknowledge is then armed for the next SCL rise, and the slave returns to waiting.
- R10: The inputs are registered once. A change of `sda_low` caused by an SCL edge appears two system clock cycles after that edge reaches `scl_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus lines |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Sampled SCL level from the master |
| sda_in | input | 1 | Sampled SDA level driven by the master |
| sda_low | output | 1 | 1 = slave pulls SDA low, 0 = slave releases SDA |

## Verification
The main function is tried with a sequence of read transfers. Each transfer carries a new word address (all zeros, all ones, single-bit values and mixed values), so every read shows the byte that the previous address loaded. A wrong bit order, a wrong image index or an off-by-one in the counter each give a different mismatch.

A write-mode transfer is run to tell the mode bit apart from the read path. A restart in mid-byte, a stop in mid-address, a bit whose SDA change coincides with the SCL rise, and idle clocking between transfers each move the acknowledge to a visibly wrong clock if the counter or the waiting state misbehaves.

// File: rtl/serial_rom_slave.sv
module serial_rom_slave #(
  parameter int DEPTH   = 256,
  parameter int IMG_MUL = 29,
  parameter int IMG_ADD = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_low
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [4:0] T_CTRL_LAST = 5'd8;
  localparam logic [4:0] T_ADDR_LAST = 5'd16;

  logic scl_q, sda_q, scl_p, sda_p;
  logic [4:0] tick;
  logic       ack_pend;
  logic [7:0] cmd, addr, data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; scl_p <= 1'b1; sda_p <= 1'b1;
    end else begin
      scl_q <= scl_in; sda_q <= sda_in;
      scl_p <= scl_q;  sda_p <= sda_q;
    end
  end

  function automatic logic [7:0] img_byte(input logic [AW-1:0] a);
    logic [31:0] t;
    t = 32'(a) * 32'(IMG_MUL) + 32'(IMG_ADD);
    return t[7:0];
  endfunction

  wire sda_chg = sda_q ^ sda_p;
  wire hi_hold = scl_q & scl_p;
  wire start_c = hi_hold & sda_chg & ~sda_q;
  wire stop_c  = hi_hold & sda_chg & sda_q;
  wire rise    = scl_q & ~scl_p;
  wire idle    = (tick == 5'd0) & ~ack_pend;
  wire [7:0] addr_nx = {addr[6:0], sda_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick <= '0; ack_pend <= 1'b0; sda_low <= 1'b0;
      cmd <= '0; addr <= '0; data <= '0;
    end else if (start_c) begin
      tick <= 5'd1; cmd <= '0; ack_pend <= 1'b0; sda_low <= 1'b0;
    end else if (stop_c) begin
      tick <= '0; ack_pend <= 1'b0; sda_low <= 1'b0;
    end else if (!idle && rise) begin
      if (ack_pend) begin
        sda_low  <= 1'b1;
        ack_pend <= 1'b0;
      end else if (!sda_chg) begin
        if (tick <= T_CTRL_LAST) begin
          cmd     <= {cmd[6:0], sda_q};
          tick    <= tick + 5'd1;
          sda_low <= 1'b0;
          if (tick == T_CTRL_LAST) ack_pend <= 1'b1;
        end else begin
          addr    <= addr_nx;
          sda_low <= cmd[0] & ~data[7];
          if (tick == T_ADDR_LAST) begin
            data     <= img_byte(addr_nx[AW-1:0]);
            ack_pend <= 1'b1;
            tick     <= '0;
          end else begin
            data <= {data[6:0], 1'b0};
            tick <= tick + 5'd1;
          end
        end
      end
    end
  end
endmodule

module serial_rom_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_q,
  input logic       scl_p,
  input logic       sda_q,
  input logic       sda_p,
  input logic [4:0] tick,
  input logic       ack_pend,
  input logic       sda_low
);
  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_p && sda_p && !sda_q) |=> (tick == 5'd1 && !ack_pend));
  // R3
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && scl_p && !sda_p && sda_q) |=> (tick == 5'd0 && !ack_pend && !sda_low));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == 5'd0 && !ack_pend && !(scl_q && scl_p && sda_p && !sda_q)) |=> (tick == 5'd0 && !ack_pend));
  // R5
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n) tick <= 5'd16);
  // R6
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_pend && scl_q && !scl_p) |=> (sda_low && !ack_pend));
  // R9
  addr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick == 5'd16 && !ack_pend && scl_q && !scl_p && sda_q == sda_p) |=> (ack_pend && tick == 5'd0));
  // R10
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> $past(scl_q && !scl_p));
endmodule

bind serial_rom_slave serial_rom_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .scl_p(scl_p), .sda_q(sda_q),
  .sda_p(sda_p), .tick(tick), .ack_pend(ack_pend), .sda_low(sda_low)
);

// File: tb/serial_rom_slave_tb.sv
`timescale 1ns/1ps
module serial_rom_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_low;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_rom_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_m), .sda_low(sda_low)
  );

  localparam logic [7:0] ADDR_TAB [6] = '{8'h10, 8'hFF, 8'h00, 8'h80, 8'h7E, 8'h01};

  function automatic logic [7:0] img(input logic [7:0] a);
    int t;
    t = int'(a) * 29 + 90;
    return t[7:0];
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic d);
    @(negedge clk);
    scl_m = c; sda_m = d;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_start();
    drive(1'b0, 1'b1); drive(1'b1, 1'b1); drive(1'b1, 1'b0);
  endtask

  task automatic bus_stop();
    drive(1'b0, sda_m); drive(1'b0, 1'b0); drive(1'b1, 1'b0); drive(1'b1, 1'b1);
  endtask

  task automatic clk_bit(input logic b, output logic o);
    drive(1'b0, sda_m); drive(1'b0, b); drive(1'b1, b);
    o = sda_low;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] obs);
    for (int k = 7; k >= 0; k--) clk_bit(b[k], obs[k]);
  endtask

  task automatic read_xfer(input logic [7:0] a, input logic [7:0] prev);
    logic [7:0] obs;
    logic o;
    bus_start();
    send_byte(8'hA1, obs);
    chk(obs, 8'h00, "R7 ctrl bits released");
    clk_bit(1'b1, o);
    chk({7'd0, o}, 8'h01, "R6 ctrl ack");
    send_byte(a, obs);
    chk(obs, ~img(prev), "R8 read data");
    clk_bit(1'b1, o);
    chk({7'd0, o}, 8'h01, "R9 addr ack");
    bus_stop();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] obs;
    logic [7:0] prev;
    logic o;
    repeat (4) @(negedge clk);
    chk({7'd0, sda_low}, 8'h00, "R1 reset released");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({7'd0, sda_low}, 8'h00, "R1 idle after reset");

    // Write-mode load of address 0x35 (R7, R9)
    bus_start();
    send_byte(8'hA0, obs);
    chk(obs, 8'h00, "R7 write ctrl released");
    clk_bit(1'b1, o);
    chk({7'd0, o}, 8'h01, "R6 write ack");
    send_byte(8'h35, obs);
    chk(obs, 8'h00, "R7 write addr released");
    clk_bit(1'b1, o);
    chk({7'd0, o}, 8'h01, "R9 write addr ack");
    bus_stop();
    prev = 8'h35;

    // Vector walk: each read shows the byte loaded by the previous address (R8, R9)
    for (int i = 0; i < 6; i++) begin
      read_xfer(ADDR_TAB[i], prev);
      prev = ADDR_TAB[i];
    end

    // R4: idle clocking with data changes is ignored
    for (int i = 0; i < 10; i++) begin
      clk_bit(logic'(i % 3 == 0), o);
      chk({7'd0, o}, 8'h00, "R4 idle no drive");
    end
    read_xfer(8'h42, prev);
    prev = 8'h42;

    // R5: SDA change coincident with SCL rise is not counted
    bus_start();
    clk_bit(1'b1, o); clk_bit(1'b0, o); clk_bit(1'b1, o);
    drive(1'b0, 1'b0);
    drive(1'b1, 1'b1);
    chk({7'd0, sda_low}, 8'h00, "R5 coincident edge ignored");
    drive(1'b0, 1'b1);
    for (int k = 4; k >= 0; k--) begin
      clk_bit(k == 0, o);
      chk({7'd0, o}, 8'h00, "R5 no early ack");
    end
    clk_bit(1'b1, o);
    chk({7'd0, o}, 8'h01, "R5 ack after eight bits");
    send_byte(8'h99, obs);
    chk(obs, ~img(prev), "R5 read mode kept");
    clk_bit(1'b1, o);
    bus_stop();
    prev = 8'h99;

    // R2: restart in mid-byte restarts the count
    bus_start();
    clk_bit(1'b1, o); clk_bit(1'b0, o); clk_bit(1'b1, o);
    bus_start();
    send_byte(8'hA1, obs);
    chk(obs, 8'h00, "R2 no ack inside restarted byte");
    clk_bit(1'b1, o);
    chk({7'd0, o}, 8'h01, "R2 ack after restart");
    bus_stop();

    // R3: stop in mid-address, then clocks ignored
    bus_start();
    send_byte(8'hA0, obs);
    clk_bit(1'b1, o);
    clk_bit(1'b0, o); clk_bit(1'b1, o); clk_bit(1'b0, o);
    bus_stop();
    chk({7'd0, sda_low}, 8'h00, "R3 released after stop");
    for (int i = 0; i < 9; i++) begin
      clk_bit(logic'(i[0]), o);
      chk({7'd0, o}, 8'h00, "R3 no ack after stop");
    end

    // R10: two-cycle latency from SCL rise to drive
    bus_start();
    send_byte(8'hA0, obs);
    @(negedge clk); scl_m = 1'b0; sda_m = 1'b1;
    repeat (3) @(negedge clk);
    scl_m = 1'b1;
    @(negedge clk);
    chk({7'd0, sda_low}, 8'h00, "R10 not after one cycle");
    @(negedge clk);
    chk({7'd0, sda_low}, 8'h01, "R10 after two cycles");
    bus_stop();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule